// File: doc/BRIEF.md
# Pin-Bank Interrupt Event Detector

This block watches a bank of general-purpose input pins and raises one interrupt line for the whole bank when a programmed event occurs on an enabled pin. Each pin is first passed through a two-stage synchroniser. By default a pin reports any change of its synchronised value. A per-pin extended-mode bit switches it to one of four qualified triggers: rising edge, falling edge, high level or low level.

Software drives the block through a simple register port. All configuration registers are set and cleared by writing ones, so a single access changes only the pins whose bits are one. A pending register records events from every pin, whether masked or not. Reading it returns its contents and clears it. The bank interrupt line is high while any pending pin is also enabled.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the enable mask, the pending register, the extended-mode bits, the level bits and the polarity bits all read zero, and `irqOut` is low.
- R2: A write to address 0x0 sets the enable bits where `wrData` is one. A write to 0x1 clears them. Zero bits leave their pins unchanged. The mask reads back at address 0x2.
- R3: Writing all ones to address 0x1 clears every enable bit in one access.
- R4: With its extended-mode bit clear, a pin sets its pending bit on either edge. The pin is sampled by two synchroniser flops and compared with the previous synchronised value, so the pending bit is visible after the third rising clock edge that follows the pin change.
- R5: Writing 0x4 sets a pin's extended-mode bit and writing 0x5 clears it (readback at 0xA). Writing 0x6 selects edge and 0x7 selects level (readback at 0xB, where 1 means level). Writing 0x8 selects rising/high and 0x9 selects falling/low (readback at 0xC, where 1 means rising/high).
- R6: In extended edge mode with rising selected, only a 0-to-1 change sets the pending bit.
- R7: In extended edge mode with falling selected, only a 1-to-0 change sets the pending bit.
- R8: In extended level mode with high selected, the pending bit is set again on every cycle while the synchronised pin is 1, so it reappears immediately after a status read.
- R9: In extended level mode with low selected, the pending bit is set on every cycle while the synchronised pin is 0.
- R10: Once the extended-mode bit is cleared, the level and polarity settings are ignored and the pin reverts to reporting both edges.
- R11: A read of address 0x3 returns the pending register and clears it on that clock edge. Bits are only lost through such a read. An event detected in the same cycle as the read stays pending.
- R12: Pending bits are set regardless of the mask. `irqOut` is high exactly when the pending register AND the mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NPINS | Asynchronous pin inputs |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | NPINS | Write-one bit vector |
| rdEn | input | 1 | Read strobe (a status read clears pending) |
| rdAddr | input | 4 | Read address |
| rdData | output | NPINS | Combinational read data for rdAddr |
| irqOut | output | 1 | Bank interrupt |

## Verification
The collision that matters is a status read and a fresh event that land in the same clock cycle. The bench changes a pin and waits exactly two clock edges, so the synchronised edge is detected in the very cycle that carries the clearing read. The read data must not show the new bit, and the following read must show it. Level-mode pins give a second collision, because their condition reasserts pending in the same cycle the read clears it. A behavioural model updated at every edge is compared with `irqOut` on every cycle and with every read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'h0;
  localparam logic [ADDR_W-1:0] A_IDIS  = 4'h1;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'h2;
  localparam logic [ADDR_W-1:0] A_PEND  = 4'h3;
  localparam logic [ADDR_W-1:0] A_XON   = 4'h4;
  localparam logic [ADDR_W-1:0] A_XOFF  = 4'h5;
  localparam logic [ADDR_W-1:0] A_EDGE  = 4'h6;
  localparam logic [ADDR_W-1:0] A_LEVEL = 4'h7;
  localparam logic [ADDR_W-1:0] A_RISE  = 4'h8;
  localparam logic [ADDR_W-1:0] A_FALL  = 4'h9;
  localparam logic [ADDR_W-1:0] A_XRD   = 4'hA;
  localparam logic [ADDR_W-1:0] A_LVRD  = 4'hB;
  localparam logic [ADDR_W-1:0] A_POLRD = 4'hC;

  typedef enum logic [2:0] {
    RD_NONE, RD_MASK, RD_PEND, RD_XMODE, RD_LEVEL, RD_POL
  } rdSel_e;

  typedef struct packed {
    logic   maskSet;
    logic   maskClr;
    logic   xSet;
    logic   xClr;
    logic   edgeSel;
    logic   levelSel;
    logic   riseSel;
    logic   fallSel;
    logic   pendClr;
    rdSel_e rdSel;
  } irqStrobes_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else if (s == 0) stage[s] <= asyncIn;
      else stage[s] <= stage[(s == 0) ? 0 : s - 1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output irqStrobes_t       stb
);
  always_comb begin
    stb          = '0;
    stb.maskSet  = wrEn && (wrAddr == A_IEN);
    stb.maskClr  = wrEn && (wrAddr == A_IDIS);
    stb.xSet     = wrEn && (wrAddr == A_XON);
    stb.xClr     = wrEn && (wrAddr == A_XOFF);
    stb.edgeSel  = wrEn && (wrAddr == A_EDGE);
    stb.levelSel = wrEn && (wrAddr == A_LEVEL);
    stb.riseSel  = wrEn && (wrAddr == A_RISE);
    stb.fallSel  = wrEn && (wrAddr == A_FALL);
    stb.pendClr  = rdEn && (rdAddr == A_PEND);
    unique case (rdAddr)
      A_MASK:  stb.rdSel = RD_MASK;
      A_PEND:  stb.rdSel = RD_PEND;
      A_XRD:   stb.rdSel = RD_XMODE;
      A_LVRD:  stb.rdSel = RD_LEVEL;
      A_POLRD: stb.rdSel = RD_POL;
      default: stb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] wrData,
  input  irqStrobes_t      stb,
  output logic [NPINS-1:0] rdData,
  output logic             irqOut,
  output logic [NPINS-1:0] pendVec,
  output logic [NPINS-1:0] maskVec
);
  logic [NPINS-1:0] syncQ, prevQ, evt;
  logic [NPINS-1:0] maskR, xModeR, levelR, riseR, pendR;

  irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncQ)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_evt
    logic anyEdge, upEdge, downEdge, qualified;
    assign anyEdge  = syncQ[p] ^ prevQ[p];
    assign upEdge   = syncQ[p] & ~prevQ[p];
    assign downEdge = ~syncQ[p] & prevQ[p];
    assign qualified = levelR[p] ? (riseR[p] ? syncQ[p] : ~syncQ[p])
                                 : (riseR[p] ? upEdge : downEdge);
    assign evt[p] = xModeR[p] ? qualified : anyEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= '0;
      maskR  <= '0;
      xModeR <= '0;
      levelR <= '0;
      riseR  <= '0;
      pendR  <= '0;
    end else begin
      prevQ <= syncQ;
      pendR <= (stb.pendClr ? '0 : pendR) | evt;
      if (stb.maskSet)  maskR  <= maskR | wrData;
      if (stb.maskClr)  maskR  <= maskR & ~wrData;
      if (stb.xSet)     xModeR <= xModeR | wrData;
      if (stb.xClr)     xModeR <= xModeR & ~wrData;
      if (stb.levelSel) levelR <= levelR | wrData;
      if (stb.edgeSel)  levelR <= levelR & ~wrData;
      if (stb.riseSel)  riseR  <= riseR | wrData;
      if (stb.fallSel)  riseR  <= riseR & ~wrData;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_MASK:  rdData = maskR;
      RD_PEND:  rdData = pendR;
      RD_XMODE: rdData = xModeR;
      RD_LEVEL: rdData = levelR;
      RD_POL:   rdData = riseR;
      default:  rdData = '0;
    endcase
  end

  assign irqOut  = |(pendR & maskR);
  assign pendVec = pendR;
  assign maskVec = maskR;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic             wrEn,
  input  logic [3:0]       wrAddr,
  input  logic [NPINS-1:0] wrData,
  input  logic             rdEn,
  input  logic [3:0]       rdAddr,
  output logic [NPINS-1:0] rdData,
  output logic             irqOut
);
  irqStrobes_t      stb;
  logic [NPINS-1:0] pendVec, maskVec;

  irq_ctrl uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr), .stb(stb)
  );

  irq_datapath #(.NPINS(NPINS), .SYNC_STAGES(2)) uDp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrData(wrData), .stb(stb),
    .rdData(rdData), .irqOut(irqOut), .pendVec(pendVec), .maskVec(maskVec)
  );
endmodule

// File: rtl/irq_detect_chk.sv
module irq_detect_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [3:0]       wrAddr,
  input logic [NPINS-1:0] wrData,
  input logic             rdEn,
  input logic [3:0]       rdAddr,
  input logic [NPINS-1:0] pendVec,
  input logic [NPINS-1:0] maskVec,
  input logic             irqOut
);
  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'h0) |=> ((maskVec & $past(wrData)) == $past(wrData)));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'h1) |=> ((maskVec & $past(wrData)) == '0));
  // R3
  mask_all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'h1 && wrData == '1) |=> (maskVec == '0));
  // R11
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && rdAddr == 4'h3) |=> ((pendVec & $past(pendVec)) == $past(pendVec)));
  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irqOut);
  // R12
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec == '0) |-> !irqOut);
endmodule

bind gpio_irq_detect irq_detect_chk #(.NPINS(NPINS)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rdEn(rdEn), .rdAddr(rdAddr), .pendVec(pendVec), .maskVec(maskVec),
  .irqOut(irqOut)
);

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rstN = 0;
  logic [N-1:0] pinIn = '0, wrData = '0;
  logic wrEn = 0, rdEn = 0;
  logic [3:0] wrAddr = '0, rdAddr = '0;
  logic [N-1:0] rdData;
  logic irqOut;
  int checks = 0, fails = 0;
  bit done = 0;

  gpio_irq_detect #(.NPINS(N)) u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [N-1:0] mS1, mS2, mPrev, mPend, mMask, mX, mLvl, mRise;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mPend = '0;
      mMask = '0; mX = '0; mLvl = '0; mRise = '0;
    end else begin
      logic [N-1:0] ev;
      for (int i = 0; i < N; i++) begin
        if (!mX[i]) ev[i] = (mS2[i] != mPrev[i]);
        else if (mLvl[i]) ev[i] = mRise[i] ? mS2[i] : !mS2[i];
        else ev[i] = mRise[i] ? (mS2[i] && !mPrev[i]) : (!mS2[i] && mPrev[i]);
      end
      mPend = ((rdEn && rdAddr == 4'h3) ? '0 : mPend) | ev;
      if (wrEn) case (wrAddr)
        4'h0: mMask = mMask | wrData;
        4'h1: mMask = mMask & ~wrData;
        4'h4: mX = mX | wrData;
        4'h5: mX = mX & ~wrData;
        4'h6: mLvl = mLvl & ~wrData;
        4'h7: mLvl = mLvl | wrData;
        4'h8: mRise = mRise | wrData;
        4'h9: mRise = mRise & ~wrData;
        default: ;
      endcase
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  function automatic logic [N-1:0] mread(logic [3:0] a);
    case (a)
      4'h2: return mMask;
      4'h3: return mPend;
      4'hA: return mX;
      4'hB: return mLvl;
      4'hC: return mRise;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle interrupt comparison (R12)
  always @(negedge clk) if (rstN && !done)
    chk("R12 irqOut", N'(irqOut), N'(|(mPend & mMask)));

  task automatic wr(logic [3:0] a, logic [N-1:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0; wrData = '0;
  endtask

  task automatic rd(logic [3:0] a, string tag, output logic [N-1:0] v);
    @(negedge clk); rdEn = 1; rdAddr = a; #1;
    v = rdData;
    chk(tag, v, mread(a));
    @(negedge clk); rdEn = 0; rdAddr = 4'h0;
  endtask

  task automatic setPin(int p, logic v);
    @(negedge clk); pinIn[p] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(4'h2, "R1 mask", v);   chk("R1 mask zero", v, '0);
    rd(4'h3, "R1 pend", v);   chk("R1 pend zero", v, '0);
    rd(4'hA, "R1 xmode", v);  chk("R1 xmode zero", v, '0);
    rd(4'hC, "R1 pol", v);
    chk("R1 irq low", N'(irqOut), '0);

    // R2 per-bit set/clear
    wr(4'h0, 32'h0000_00F0);
    rd(4'h2, "R2 mask set", v);  chk("R2 mask F0", v, 32'h0000_00F0);
    wr(4'h1, 32'h0000_0010);
    rd(4'h2, "R2 mask clr", v);  chk("R2 mask E0", v, 32'h0000_00E0);

    // R4 default both-edge, pin 0 (masked: R12 pending without irq)
    setPin(0, 1); idle(4);
    rd(4'h3, "R4 rise pend", v); chk("R4 rise bit0", v & 32'h1, 32'h1);
    setPin(0, 0); idle(4);
    wr(4'h0, 32'h1);                 // R12 now irq should rise
    chk("R12 irq enabled", N'(irqOut), N'(1));
    rd(4'h3, "R4 fall pend", v); chk("R4 fall bit0", v & 32'h1, 32'h1);
    rd(4'h3, "R11 cleared", v);  chk("R11 cleared", v, '0);

    // R5/R6 rising edge on pin 1
    wr(4'h4, 32'h2); wr(4'h6, 32'h2); wr(4'h8, 32'h2);
    rd(4'hA, "R5 xmode rb", v);  chk("R5 xmode bit1", v, 32'h2);
    rd(4'hC, "R5 pol rb", v);    chk("R5 pol bit1", v, 32'h2);
    setPin(1, 1); idle(4);
    rd(4'h3, "R6 rise", v);      chk("R6 rise bit1", v, 32'h2);
    setPin(1, 0); idle(4);
    rd(4'h3, "R6 no fall", v);   chk("R6 no fall", v, '0);

    // R7 falling edge on pin 2
    wr(4'h4, 32'h4); wr(4'h9, 32'h4);
    setPin(2, 1); idle(4);
    rd(4'h3, "R7 no rise", v);   chk("R7 no rise", v, '0);
    setPin(2, 0); idle(4);
    rd(4'h3, "R7 fall", v);      chk("R7 fall bit2", v, 32'h4);

    // R8 high level on pin 3, reasserts after clear
    wr(4'h4, 32'h8); wr(4'h7, 32'h8); wr(4'h8, 32'h8);
    rd(4'hB, "R5 level rb", v);  chk("R5 level bit3", v, 32'h8);
    setPin(3, 1); idle(4);
    rd(4'h3, "R8 level1", v);    chk("R8 level bit3", v, 32'h8);
    rd(4'h3, "R8 level2", v);    chk("R8 reassert bit3", v, 32'h8);

    // R10 drop extended mode on pin 3: level ignored, both edges
    wr(4'h5, 32'h8); idle(2);
    rd(4'h3, "R10 flush", v);
    rd(4'h3, "R10 no level", v); chk("R10 no level", v, '0);
    setPin(3, 0); idle(4);
    rd(4'h3, "R10 fall", v);     chk("R10 fall bit3", v, 32'h8);

    // R9 low level on pin 4
    wr(4'h4, 32'h10); wr(4'h9, 32'h10); wr(4'h7, 32'h10); idle(2);
    rd(4'h3, "R9 low1", v);      chk("R9 low bit4", v & 32'h10, 32'h10);
    rd(4'h3, "R9 low2", v);      chk("R9 reassert bit4", v, 32'h10);
    setPin(4, 1); idle(4);
    rd(4'h3, "R9 flush", v);
    rd(4'h3, "R9 high none", v); chk("R9 high none", v, '0);

    // R11 event in same cycle as clearing read (pin 5, both-edge)
    setPin(5, 1); idle(2);
    rd(4'h3, "R11 same-cycle read", v); chk("R11 not yet bit5", v & 32'h20, '0);
    rd(4'h3, "R11 kept", v);     chk("R11 kept bit5", v, 32'h20);

    // R3 all-ones disable, with pending unmasked beforehand
    setPin(0, 1); idle(4);
    wr(4'h1, '1);
    rd(4'h2, "R3 mask", v);      chk("R3 mask zero", v, '0);
    chk("R3 irq low", N'(irqOut), '0);
    rd(4'h3, "R3 pend", v);      chk("R3 pend kept", v & 32'h1, 32'h1);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule